// File: doc/BRIEF.md
# DMA Request Handshake Agent

This block sits on the peripheral side of a processor's DMA unit and owns the two active-low lines that a peripheral presents to it: the transfer request and the end-of-process marker. When the local logic has data waiting, the agent pulls the request low. It then watches the DMA acknowledge line and the local bus strobes (address strobe, last-access strobe, ready) so that it can release the request at a moment that is legal for the selected transfer mode.

Two withdrawal modes exist. In fly-by packing or unpacking mode, the request must already be released while acknowledge is still low. The agent therefore releases it on the final bus access of the acknowledged request. That access is the one where the last-access strobe and ready are both low within an access opened by the address strobe. In every other mode, the agent keeps the request low for as long as acknowledge is low. It releases the request on the first clock edge that samples acknowledge high, which is one edge inside the allowed two-edge window.

On command, the agent drives a level end-of-process pulse whose length can be programmed and is clamped to the legal span of 2 to 15 clocks. A sticky error flag records any acknowledge that arrives while the agent has nothing outstanding. All outputs come from registers.

Top module: `dma_req_agent`

## Requirements
- R1: While reset is asserted (rst_n low), req_n and eop_n are high and err is low.
- R2: With the agent idle, an edge that samples xfer_pend high drives req_n low after that edge. The request then stays low until a withdrawal condition occurs.
- R3: With flyby_mode low, req_n stays low while ack_n is low, and bus strobes have no effect on it. req_n goes high after the first edge that samples ack_n high.
- R4: With flyby_mode high, req_n goes high after the edge that samples a final access while ack_n is low. A final access is blast_n low and rdy_n low, either in the same cycle as ads_n low or in an access already opened by ads_n. Release therefore happens while acknowledge is still low.
- R5: In fly-by mode, an access that ends with blast_n high, or a cycle with blast_n low but rdy_n high, leaves req_n low.
- R6: After a fly-by release, no new request is raised until an edge has sampled ack_n high. The next edge may then raise a request. Acknowledge staying low during this wait does not set err.
- R7: An edge that samples eop_cmd high while no pulse is running drives eop_n low for exactly L clocks. L is eop_len when eop_len is between 2 and 15.
- R8: eop_len values 0 and 1 give a 2-clock pulse, and values 16 to 31 give a 15-clock pulse.
- R9: eop_cmd is ignored while a pulse is running, so holding it high does not lengthen or restart that pulse.
- R10: An edge that samples ack_n low while the agent is idle sets err after that edge. err then stays high without further violations. An acknowledge during an outstanding request leaves err low.
- R11: An edge that samples err_clr high clears err, unless the same edge also samples a violation, in which case err stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_pend | input | 1 | Local logic has a transfer waiting |
| flyby_mode | input | 1 | 1 selects fly-by packing/unpacking withdrawal, 0 normal |
| eop_cmd | input | 1 | Start an end-of-process pulse |
| eop_len | input | 5 | Requested pulse length in clocks (clamped to 2..15) |
| err_clr | input | 1 | Synchronous clear of the sticky error flag |
| ack_n | input | 1 | DMA acknowledge, active low |
| ads_n | input | 1 | Bus address strobe, active low |
| blast_n | input | 1 | Bus last-access strobe, active low |
| rdy_n | input | 1 | Bus ready, active low |
| req_n | output | 1 | DMA request, active low, registered |
| eop_n | output | 1 | End-of-process, active low, registered |
| err | output | 1 | Sticky protocol-violation flag |

## Verification
Every output is one register deep. The request, release, error set and error clear results therefore all appear on the first clock edge that samples their cause. The bench drives inputs 1 ns after a rising edge and reads the outputs 1 ns after the next edge, so each check lands exactly one clock after its stimulus. End-of-process length is measured by counting the samples in which eop_n is low, beginning with the sample just after the edge that accepted the command. That count equals the clamped length exactly, with no slack allowed.

// File: rtl/dma_agent_pkg.sv
package dma_agent_pkg;

  localparam int unsigned EOP_MIN_DEF = 2;
  localparam int unsigned EOP_MAX_DEF = 15;
  localparam int unsigned LEN_W_DEF   = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_ACKED = 2'd2,
    ST_DRAIN = 2'd3
  } req_state_e;

endpackage

// File: rtl/dma_bus_watch.sv
module dma_bus_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  input  logic ads_n,
  input  logic blast_n,
  input  logic rdy_n,
  output logic final_w
);
  logic open_q;
  logic last_w;

  // a last access completes when last strobe and ready meet inside an open access
  assign last_w  = !blast_n && !rdy_n && (open_q || !ads_n);
  assign final_w = last_w && !ack_n;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= (open_q || !ads_n) && !last_w;
  end
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_agent_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_pend,
  input  logic flyby_mode,
  input  logic ack_n,
  input  logic final_w,
  output logic req_n,
  output logic no_req_w
);
  req_state_e st_q, st_d;
  logic       req_n_q, req_n_d;

  assign req_n    = req_n_q;
  assign no_req_w = (st_q == ST_IDLE);

  always_comb begin
    st_d    = st_q;
    req_n_d = req_n_q;
    unique case (st_q)
      ST_IDLE: if (xfer_pend) begin
        st_d = ST_REQ; req_n_d = 1'b0;
      end
      ST_REQ: begin
        if (flyby_mode && final_w) begin
          st_d = ST_DRAIN; req_n_d = 1'b1;
        end else if (!ack_n) begin
          st_d = ST_ACKED;
        end
      end
      ST_ACKED: begin
        if (flyby_mode && final_w) begin
          st_d = ST_DRAIN; req_n_d = 1'b1;
        end else if (ack_n) begin
          st_d = ST_IDLE; req_n_d = 1'b1;
        end
      end
      ST_DRAIN: if (ack_n) st_d = ST_IDLE;
      default: begin
        st_d = ST_IDLE; req_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      req_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      req_n_q <= req_n_d;
    end
  end

  // R4
  flyby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flyby_mode && $rose(ack_n) |-> req_n_q);

  // R3
  normal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flyby_mode && $rose(ack_n) && !req_n_q && $past(st_q == ST_ACKED) |=> req_n_q);

  // R3
  normal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flyby_mode && !req_n_q && !ack_n |=> !req_n_q);
endmodule

// File: rtl/dma_eop_gen.sv
module dma_eop_gen #(
  parameter int unsigned EOP_MIN = dma_agent_pkg::EOP_MIN_DEF,
  parameter int unsigned EOP_MAX = dma_agent_pkg::EOP_MAX_DEF,
  parameter int unsigned LEN_W   = dma_agent_pkg::LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eop_cmd,
  input  logic [LEN_W-1:0] eop_len,
  output logic             eop_n
);
  localparam int unsigned CNT_W = $clog2(EOP_MAX + 1);

  function automatic logic [CNT_W-1:0] clamp_len(input logic [LEN_W-1:0] len);
    int unsigned v;
    v = int'(len);
    if (v < EOP_MIN)      v = EOP_MIN;
    else if (v > EOP_MAX) v = EOP_MAX;
    return CNT_W'(v);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             eop_n_q;
  logic             busy_w, start_w;

  assign busy_w  = (cnt_q != '0);
  assign start_w = eop_cmd && !busy_w;
  assign eop_n   = eop_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      eop_n_q <= 1'b1;
    end else if (start_w) begin
      cnt_q   <= clamp_len(eop_len);
      eop_n_q <= 1'b0;
    end else if (busy_w) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) eop_n_q <= 1'b1;
    end
  end

  // checker: length of the current low run of eop_n
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      low_run_q <= '0;
    else if (eop_n_q)                low_run_q <= '0;
    else if (low_run_q != '1)        low_run_q <= low_run_q + 1'b1;
  end

  // R7
  eop_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_n_q) |-> (low_run_q >= (CNT_W+1)'(EOP_MIN)));

  // R8
  eop_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= (CNT_W+1)'(EOP_MAX));
endmodule

// File: rtl/dma_err_mon.sv
module dma_err_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  input  logic no_req_w,
  input  logic err_clr,
  output logic err
);
  logic err_q;
  logic viol_w;

  assign viol_w = !ack_n && no_req_w;
  assign err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (viol_w)  err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr |=> err_q);

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && ack_n |=> !err_q);
endmodule

// File: rtl/dma_req_agent.sv
module dma_req_agent #(
  parameter int unsigned EOP_MIN = dma_agent_pkg::EOP_MIN_DEF,
  parameter int unsigned EOP_MAX = dma_agent_pkg::EOP_MAX_DEF,
  parameter int unsigned LEN_W   = dma_agent_pkg::LEN_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_pend,
  input  logic             flyby_mode,
  input  logic             eop_cmd,
  input  logic [LEN_W-1:0] eop_len,
  input  logic             err_clr,
  input  logic             ack_n,
  input  logic             ads_n,
  input  logic             blast_n,
  input  logic             rdy_n,
  output logic             req_n,
  output logic             eop_n,
  output logic             err
);
  logic final_w;
  logic no_req_w;

  dma_bus_watch u_watch (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ads_n(ads_n),
    .blast_n(blast_n), .rdy_n(rdy_n), .final_w(final_w)
  );

  dma_req_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .xfer_pend(xfer_pend), .flyby_mode(flyby_mode),
    .ack_n(ack_n), .final_w(final_w), .req_n(req_n), .no_req_w(no_req_w)
  );

  dma_eop_gen #(.EOP_MIN(EOP_MIN), .EOP_MAX(EOP_MAX), .LEN_W(LEN_W)) u_eop (
    .clk(clk), .rst_n(rst_n), .eop_cmd(eop_cmd), .eop_len(eop_len), .eop_n(eop_n)
  );

  dma_err_mon u_err (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .no_req_w(no_req_w),
    .err_clr(err_clr), .err(err)
  );
endmodule

// File: tb/tb_dma_req_agent.sv
module tb_dma_req_agent;
  logic       clk = 1'b0;
  logic       rst_n, xfer_pend, flyby_mode, eop_cmd, err_clr;
  logic       ack_n, ads_n, blast_n, rdy_n;
  logic [4:0] eop_len;
  logic       req_n, eop_n, err;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_req_agent dut (
    .clk(clk), .rst_n(rst_n), .xfer_pend(xfer_pend), .flyby_mode(flyby_mode),
    .eop_cmd(eop_cmd), .eop_len(eop_len), .err_clr(err_clr), .ack_n(ack_n),
    .ads_n(ads_n), .blast_n(blast_n), .rdy_n(rdy_n),
    .req_n(req_n), .eop_n(eop_n), .err(err)
  );

  localparam int N_EOP = 7;
  localparam int LEN_TAB [N_EOP] = '{0, 1, 2, 7, 15, 16, 31};
  localparam int EXP_TAB [N_EOP] = '{2, 2, 2, 7, 15, 15, 15};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_idle();
    ads_n = 1'b1; blast_n = 1'b1; rdy_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; xfer_pend = 1'b0; flyby_mode = 1'b0; eop_cmd = 1'b0;
    eop_len = 5'd0; err_clr = 1'b0; ack_n = 1'b1; bus_idle();
    step(3);
    chk("R1 req_n", req_n, 1); chk("R1 eop_n", eop_n, 1); chk("R1 err", err, 0);
    rst_n = 1'b1;
    step(1);

    // end-of-process length table (R7, R8)
    for (int i = 0; i < N_EOP; i++) begin
      eop_len = 5'(LEN_TAB[i]); eop_cmd = 1'b1;
      step(1);
      eop_cmd = 1'b0; w = 0;
      while (eop_n == 1'b0 && w < 40) begin w++; step(1); end
      chk((LEN_TAB[i] >= 2 && LEN_TAB[i] <= 15) ? "R7 eop width" : "R8 eop clamp", w, EXP_TAB[i]);
      step(2);
    end

    // R9: command held high during a pulse does not extend it
    eop_len = 5'd5; eop_cmd = 1'b1;
    step(1); w = 0;
    while (eop_n == 1'b0 && w < 40) begin w++; step(1); end
    eop_cmd = 1'b0;
    chk("R9 held cmd width", w, 5);
    step(2);
    chk("R9 no retrigger", eop_n, 1);

    // normal mode request (R2, R3, R10)
    flyby_mode = 1'b0; xfer_pend = 1'b1;
    step(1);
    chk("R2 request raised", req_n, 0);
    xfer_pend = 1'b0;
    step(2);
    chk("R2 request held", req_n, 0);
    ack_n = 1'b0;
    step(1);
    ads_n = 1'b0; blast_n = 1'b0; rdy_n = 1'b0;
    step(1);
    bus_idle();
    chk("R3 strobes ignored", req_n, 0);
    step(2);
    chk("R3 held under ack", req_n, 0);
    ack_n = 1'b1;
    step(1);
    chk("R3 release after ack high", req_n, 1);
    chk("R10 no err during request", err, 0);
    step(2);

    // fly-by mode (R4, R5, R6)
    flyby_mode = 1'b1; xfer_pend = 1'b1;
    step(1);
    chk("R2 flyby request", req_n, 0);
    xfer_pend = 1'b0; ack_n = 1'b0;
    step(1);
    ads_n = 1'b0;
    step(1);
    ads_n = 1'b1; rdy_n = 1'b0;
    step(1);
    chk("R5 non-last access", req_n, 0);
    rdy_n = 1'b1; ads_n = 1'b0;
    step(1);
    ads_n = 1'b1; blast_n = 1'b0;
    step(1);
    chk("R5 last without ready", req_n, 0);
    rdy_n = 1'b0;
    step(1);
    bus_idle();
    chk("R4 release on final access", req_n, 1);
    chk("R4 ack still low", ack_n, 0);
    xfer_pend = 1'b1;
    step(2);
    chk("R6 no request while ack low", req_n, 1);
    chk("R6 no err in drain", err, 0);
    ack_n = 1'b1;
    step(1);
    chk("R6 still idle at ack edge", req_n, 1);
    step(1);
    chk("R6 new request after ack high", req_n, 0);
    xfer_pend = 1'b0; flyby_mode = 1'b0; ack_n = 1'b0;
    step(2);
    ack_n = 1'b1;
    step(1);
    chk("R3 second release", req_n, 1);
    step(2);

    // error flag (R10, R11)
    ack_n = 1'b0;
    step(1);
    ack_n = 1'b1;
    chk("R10 err set", err, 1);
    step(3);
    chk("R10 err sticky", err, 1);
    err_clr = 1'b1;
    step(1);
    err_clr = 1'b0;
    chk("R11 err cleared", err, 0);
    ack_n = 1'b0; err_clr = 1'b1;
    step(1);
    ack_n = 1'b1; err_clr = 1'b0;
    chk("R11 violation beats clear", err, 1);
    err_clr = 1'b1;
    step(1);
    err_clr = 1'b0;
    chk("R11 final clear", err, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule